// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a single register write into software-generated interrupts (SGIs) that are raised on a set of CPUs. The written word carries an SGI number, a list of target CPUs and a filter mode. The filter mode chooses how the targets are found. The list can be used exactly as written. The targets can be every online CPU except the writer. The target can also be the writer alone.

For each target CPU the block pulses a pending-set strobe for that SGI. It also records the writer in a sticky per-target, per-SGI source bitmap. The CPU interface removes a source bit through a dedicated clear input once that request has been taken.

Every accepted write also pulses a recompute request, so the surrounding interrupt logic re-evaluates its pending state. The register itself reads as zero.

Top module: `sgi_dispatch`

## Requirements
- R1: Field positions in the written word:
  - bits [3:0] give the SGI number;
  - bits [23:16] give the target list, where bit 16+c selects CPU c;
  - bits [25:24] give the filter mode.
  
  All other bits are ignored.
- R2: In filter mode 0, every CPU c whose list bit is set gets a pending pulse on `pend_set_o[c*16+sgi]`. The pulse is high for exactly the one cycle after the write cycle. No other `pend_set_o` bit is set.
- R3: In filter mode 0 with an all-zero target list, nothing is dispatched: no pending pulse, and no source bitmap changes.
- R4: In filter mode 1, the targets are every CPU c with c < `online_cpus_i`, except the writer `wr_cpu_i`.
- R5: In filter mode 2, the only target is the writer `wr_cpu_i`.
- R6: Filter mode 3 is reserved and dispatches nothing.
- R7: For every target c, source bit `wr_cpu_i` of the bitmap for (c, sgi) is set. This is bit `(c*16+sgi)*8+wr_cpu_i` of `src_mask_o`. The bit becomes visible in the cycle after the write. Source bits accumulate and stay set until they are cleared.
- R8: A clear request clears exactly one source bit (`clr_tgt_i`, `clr_sgi_i`, `clr_src_i`) in the following cycle. If a write sets the same bit in the same cycle, the set wins.
- R9: `rd_data_o` always reads zero.
- R10: `recalc_o` pulses for one cycle after every accepted write. This includes writes that dispatch nothing.
- R11: While reset is asserted, all pending pulses, all source bitmaps and `recalc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write to the SGI register this cycle |
| wr_data_i | input | 32 | Written word |
| wr_cpu_i | input | 3 | ID of the writing CPU |
| online_cpus_i | input | 4 | Number of online CPUs (1..8) |
| rd_data_o | output | 32 | Read data of the register, always zero |
| clr_valid_i | input | 1 | Clear one source bit this cycle |
| clr_tgt_i | input | 3 | Target CPU of the clear |
| clr_sgi_i | input | 4 | SGI number of the clear |
| clr_src_i | input | 3 | Source CPU bit to clear |
| pend_set_o | output | 128 | Pending-set pulses, bit c*16+sgi |
| src_mask_o | output | 1024 | Source bitmaps, bit (c*16+sgi)*8+src |
| recalc_o | output | 1 | Pending-state recompute pulse |

## Verification
Pending pulses, source bitmap updates, clears and the recompute pulse each pass through one register. All of them are therefore due one cycle after the input cycle that caused them. `rd_data_o` has no latency.

The bench drives every input on a falling edge. It then samples all outputs 2 ns after the next rising edge. Expected values come from a per-(target, SGI) source model: clears are applied first and sets after, so a set wins.

Because each step compares the full pending vector, a missing pulse is caught. So is a pulse that lingers for a second cycle, and so is a stray pulse after a write that should do nothing.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SGI_LSB    = 0;
  localparam int unsigned LIST_LSB   = 16;
  localparam int unsigned FILT_LSB   = 24;
  localparam int unsigned MAX_CPUS   = 8;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'd0,
    FILT_OTHERS = 2'd1,
    FILT_SELF   = 2'd2,
    FILT_RSVD   = 2'd3
  } filt_e;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_SGIS = 16,
  localparam int unsigned CPU_ID_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W    = $clog2(NUM_CPUS + 1),
  localparam int unsigned SGI_W    = $clog2(NUM_SGIS)
) (
  input  logic [WORD_W-1:0]   word_i,
  input  logic [CPU_ID_W-1:0] cpu_i,
  input  logic [CNT_W-1:0]    online_i,
  output logic [SGI_W-1:0]    sgi_o,
  output logic [NUM_CPUS-1:0] tgt_o
);
  filt_e                filt;
  logic [NUM_CPUS-1:0]  online_mask;
  logic [NUM_CPUS-1:0]  self_mask;

  assign filt  = filt_e'(word_i[FILT_LSB +: 2]);
  assign sgi_o = word_i[SGI_LSB +: SGI_W];

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      online_mask[c] = (CNT_W'(c) < online_i);
      self_mask[c]   = (CPU_ID_W'(c) == cpu_i);
    end
  end

  always_comb begin
    unique case (filt)
      FILT_LIST:   tgt_o = word_i[LIST_LSB +: NUM_CPUS];
      FILT_OTHERS: tgt_o = online_mask & ~self_mask;
      FILT_SELF:   tgt_o = self_mask;
      default:     tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank #(
  parameter int unsigned NUM_SGIS = 16,
  parameter int unsigned SRC_W    = 8,
  localparam int unsigned SGI_W    = $clog2(NUM_SGIS),
  localparam int unsigned SRC_ID_W = $clog2(SRC_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      set_i,
  input  logic [SGI_W-1:0]          set_sgi_i,
  input  logic [SRC_ID_W-1:0]       set_src_i,
  input  logic                      clr_i,
  input  logic [SGI_W-1:0]          clr_sgi_i,
  input  logic [SRC_ID_W-1:0]       clr_src_i,
  output logic [NUM_SGIS-1:0]       pend_o,
  output logic [NUM_SGIS*SRC_W-1:0] mask_o
);
  logic [SRC_W-1:0] set_oh, clr_oh;

  assign set_oh = SRC_W'(1) << set_src_i;
  assign clr_oh = SRC_W'(1) << clr_src_i;

  for (genvar s = 0; s < NUM_SGIS; s++) begin : g_sgi
    logic             set_hit, clr_hit;
    logic [SRC_W-1:0] mask_q;
    logic             pend_q;

    assign set_hit = set_i && (set_sgi_i == SGI_W'(s));
    assign clr_hit = clr_i && (clr_sgi_i == SGI_W'(s));

    // clear first, set second: a same-cycle set wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        pend_q <= 1'b0;
      end else begin
        pend_q <= set_hit;
        mask_q <= (mask_q & ~(clr_hit ? clr_oh : '0)) | (set_hit ? set_oh : '0);
      end
    end

    assign pend_o[s]                 = pend_q;
    assign mask_o[s*SRC_W +: SRC_W]  = mask_q;

    p_src_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(clr_i && clr_sgi_i == SGI_W'(s)) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
    p_set_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && set_sgi_i == SGI_W'(s)) |=> (pend_q && mask_q[$past(set_src_i)]));
    p_clr_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && clr_sgi_i == SGI_W'(s) && !(set_i && set_sgi_i == SGI_W'(s) && set_src_i == clr_src_i))
      |=> !mask_q[$past(clr_src_i)]);
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_SGIS = 16,
  localparam int unsigned CPU_ID_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W    = $clog2(NUM_CPUS + 1),
  localparam int unsigned SGI_W    = $clog2(NUM_SGIS),
  localparam int unsigned PEND_W   = NUM_CPUS * NUM_SGIS,
  localparam int unsigned MASK_W   = PEND_W * NUM_CPUS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [CPU_ID_W-1:0] wr_cpu_i,
  input  logic [CNT_W-1:0]    online_cpus_i,
  output logic [WORD_W-1:0]   rd_data_o,
  input  logic                clr_valid_i,
  input  logic [CPU_ID_W-1:0] clr_tgt_i,
  input  logic [SGI_W-1:0]    clr_sgi_i,
  input  logic [CPU_ID_W-1:0] clr_src_i,
  output logic [PEND_W-1:0]   pend_set_o,
  output logic [MASK_W-1:0]   src_mask_o,
  output logic                recalc_o
);
  localparam int unsigned BANK_W = NUM_SGIS * NUM_CPUS;

  logic [SGI_W-1:0]    sgi_num;
  logic [NUM_CPUS-1:0] tgt;
  logic                recalc_q;

  sgi_decode #(.NUM_CPUS(NUM_CPUS), .NUM_SGIS(NUM_SGIS)) u_decode (
    .word_i   (wr_data_i),
    .cpu_i    (wr_cpu_i),
    .online_i (online_cpus_i),
    .sgi_o    (sgi_num),
    .tgt_o    (tgt)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_tgt
    sgi_src_bank #(.NUM_SGIS(NUM_SGIS), .SRC_W(NUM_CPUS)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (wr_valid_i && tgt[c]),
      .set_sgi_i (sgi_num),
      .set_src_i (wr_cpu_i),
      .clr_i     (clr_valid_i && (clr_tgt_i == CPU_ID_W'(c))),
      .clr_sgi_i (clr_sgi_i),
      .clr_src_i (clr_src_i),
      .pend_o    (pend_set_o[c*NUM_SGIS +: NUM_SGIS]),
      .mask_o    (src_mask_o[c*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recalc_q <= 1'b0;
    else         recalc_q <= wr_valid_i;
  end

  assign recalc_o  = recalc_q;
  assign rd_data_o = '0;

  p_recalc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> recalc_o);
  p_pulse_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_set_o) |-> $past(wr_valid_i));
  p_rsvd_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_data_i[FILT_LSB +: 2] == 2'd3) |=> (pend_set_o == '0));
  p_self_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_data_i[FILT_LSB +: 2] == 2'd2) |=> ($countones(pend_set_o) == 1));
endmodule

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
  localparam int NC = 8;
  localparam int NS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [2:0]   wr_cpu = '0;
  logic [3:0]   online = 4'd8;
  logic         clr_valid = 1'b0;
  logic [2:0]   clr_tgt = '0;
  logic [3:0]   clr_sgi = '0;
  logic [2:0]   clr_src = '0;
  logic [31:0]  rd_data;
  logic [127:0] pend_set;
  logic [1023:0] src_mask;
  logic         recalc;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [NC][NS];

  always #4 clk = ~clk;

  sgi_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_cpu_i(wr_cpu), .online_cpus_i(online), .rd_data_o(rd_data),
    .clr_valid_i(clr_valid), .clr_tgt_i(clr_tgt), .clr_sgi_i(clr_sgi),
    .clr_src_i(clr_src), .pend_set_o(pend_set), .src_mask_o(src_mask),
    .recalc_o(recalc)
  );

  task automatic chk(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_tgt(input logic [31:0] d, input logic [2:0] w, input logic [3:0] on);
    logic [7:0] all = '0;
    for (int c = 0; c < NC; c++) all[c] = (c < on);
    case (d[25:24])
      2'd0: return d[23:16];
      2'd1: return all & ~(8'd1 << w);
      2'd2: return 8'd1 << w;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [1023:0] model_vec();
    logic [1023:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) v[(c*NS+s)*8 +: 8] = model[c][s];
    return v;
  endfunction

  task automatic step(input logic wv, input logic [31:0] d, input logic [2:0] w, input logic [3:0] on,
                      input logic cv, input logic [2:0] ct, input logic [3:0] cs, input logic [2:0] cb,
                      input string req);
    logic [127:0] ep = '0;
    logic [7:0]   t;
    @(negedge clk);
    wr_valid = wv; wr_data = d; wr_cpu = w; online = on;
    clr_valid = cv; clr_tgt = ct; clr_sgi = cs; clr_src = cb;
    chk({req, " R9 read zero"}, {992'd0, rd_data}, '0);
    if (cv) model[ct][cs][cb] = 1'b0;
    t = wv ? exp_tgt(d, w, on) : 8'd0;
    for (int c = 0; c < NC; c++)
      if (t[c]) begin
        ep[c*NS + int'(d[3:0])] = 1'b1;
        model[c][d[3:0]][w] = 1'b1;
      end
    @(posedge clk);
    #2;
    chk({req, " pend"}, {896'd0, pend_set}, {896'd0, ep});
    chk({req, " R7 src mask"}, src_mask, model_vec());
    chk({req, " R10 recalc"}, {1023'd0, recalc}, {1023'd0, wv});
  endtask

  task automatic idle(input string req);
    step(1'b0, '0, '0, 4'd8, 1'b0, '0, '0, '0, req);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) model[c][s] = '0;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #2;
    chk("R11 reset pend", {896'd0, pend_set}, '0);
    chk("R11 reset mask", src_mask, '0);
    chk("R11 reset recalc", {1023'd0, recalc}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: explicit list CPUs 1,4,7, SGI 5 from CPU 2
    step(1'b1, 32'h0092_0005, 3'd2, 4'd8, 1'b0, 0, 0, 0, "R2 list");
    idle("R2 pulse one cycle");
    // R3: empty list
    step(1'b1, 32'h0000_0009, 3'd6, 4'd8, 1'b0, 0, 0, 0, "R3 empty list");
    // R4: others, full and single online
    step(1'b1, 32'h0100_0003, 3'd3, 4'd8, 1'b0, 0, 0, 0, "R4 others 8 online");
    step(1'b1, 32'h0100_000C, 3'd1, 4'd3, 1'b0, 0, 0, 0, "R4 others 3 online");
    step(1'b1, 32'h01FF_0004, 3'd0, 4'd1, 1'b0, 0, 0, 0, "R4 others alone");
    // R5: self
    step(1'b1, 32'h02FF_000F, 3'd7, 4'd8, 1'b0, 0, 0, 0, "R5 self");
    // R6: reserved
    step(1'b1, 32'h03FF_0002, 3'd4, 4'd8, 1'b0, 0, 0, 0, "R6 reserved");
    // R1: junk in unused bits
    step(1'b1, 32'hFC00_FFF1, 3'd5, 4'd8, 1'b0, 0, 0, 0, "R1 unused bits");
    step(1'b1, 32'hF801_A7E6, 3'd5, 4'd8, 1'b0, 0, 0, 0, "R1 unused bits list");
    // R7: accumulate second source
    step(1'b1, 32'h0010_0005, 3'd6, 4'd8, 1'b0, 0, 0, 0, "R7 accumulate");
    // R8: clear, then collision where set wins
    step(1'b0, '0, 3'd0, 4'd8, 1'b1, 3'd4, 4'd5, 3'd2, "R8 clear");
    step(1'b1, 32'h0010_0005, 3'd6, 4'd8, 1'b1, 3'd4, 4'd5, 3'd6, "R8 set wins");
    step(1'b0, '0, 3'd0, 4'd8, 1'b1, 3'd4, 4'd5, 3'd5, "R8 clear absent bit");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d = $urandom;
      logic [3:0]  on = 4'($urandom_range(1, 8));
      logic [2:0]  w  = 3'($urandom_range(0, int'(on) - 1));
      logic        cv = ($urandom_range(0, 9) < 4);
      logic [2:0]  ct = 3'($urandom);
      logic [3:0]  cs = 4'($urandom);
      logic [2:0]  cb = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        ct = 3'($urandom_range(0, 7)); cs = d[3:0]; cb = w;
      end
      step($urandom_range(0, 9) < 7, d, w, on, cv, ct, cs, cb, "R2 R7 R8 random");
    end
    idle("R10 idle tail");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule